// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block runs on the pixel clock and produces horizontal sync, vertical sync and a data-enable window for a resolution chosen at run time. Two counters sweep each frame: a pixel counter runs along every line and wraps, and a line counter advances once per wrap. Per axis, the configuration gives the total count, the sync width, and the first and one-past-last count of the enable window. The window is given as explicit counter values and is not worked out from porch sizes. For a 1080p frame, the horizontal values are 2200 total, 44 sync, 192 min and 2112 max. The vertical values are 1125 total, 5 sync, 41 min and 1121 max.

During the enable window the block drives a 24-bit pixel taken from one of three sources. The first is a constant colour input. The second is an internal ramp that counts the enabled pixels of the frame. The third is an external stream, which is paced by a one-cycle request strobe for each pixel it must supply. A control FSM has two states. In `ST_HOLD` (the `run_en` low) the counters are cleared and every output is quiet. In `ST_RUN` the counters step once per clock. The transition `ST_HOLD -> ST_RUN` happens on a clock edge that samples `run_en` high, and `ST_RUN -> ST_HOLD` happens on an edge that samples it low.

Top module: `pix_timing_gen`

## Requirements
- R1: While `rst_n` is low, or in the cycle after an edge that sampled `run_en` low, `hsync`, `vsync`, `de` and `pix_req` are 0 and `pix_data` is 0. `rst_n` overrides `run_en`.
- R2: After an edge that samples `run_en` high from hold, the pixel count is 0 in the first cycle. It then rises by one each clock up to `h_total`-1 and returns to 0. `hsync` is active-high while the pixel count is below `h_sync_w`, so a width of 0 never asserts it.
- R3: The line count is 0 in the first running cycle and advances only on the cycle after the pixel count is `h_total`-1. It wraps after `v_total`-1. `vsync` is active-high while the line count is below `v_sync_w`.
- R4: `de` is high exactly when the pixel count is at least `h_de_min` and below `h_de_max`, and the line count is at least `v_de_min` and below `v_de_max`.
- R5: With `src_sel` = 2'b11, `pix_data` equals `const_rgb` on every `de` cycle.
- R6: With `src_sel` = 2'b10, `pix_data` is a ramp. It is 0 on the first `de` cycle of each frame and one higher on each later `de` cycle, modulo 2^24.
- R7: With `src_sel` = 2'b00 or 2'b01, `pix_data` equals `strm_data` in the same cycle on every `de` cycle. `pix_req` equals `de` in these modes and is 0 in the other two.
- R8: `pix_data` is 0 on every running cycle where `de` is low, whatever the source.
- R9: Dropping `run_en` in the middle of a frame and raising it again restarts the frame at pixel 0, line 0, and restarts the ramp at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generator enable; low holds all counters at zero |
| src_sel | input | 2 | Pixel source: 11 constant, 10 ramp, 0x stream |
| const_rgb | input | 24 | Constant colour |
| strm_data | input | 24 | External stream pixel |
| h_total | input | 16 | Clocks per line |
| h_sync_w | input | 16 | Horizontal sync width in clocks |
| h_de_min | input | 16 | First pixel count inside the enable window |
| h_de_max | input | 16 | First pixel count after the enable window |
| v_total | input | 16 | Lines per frame |
| v_sync_w | input | 16 | Vertical sync width in lines |
| v_de_min | input | 16 | First line inside the enable window |
| v_de_max | input | 16 | First line after the enable window |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |
| de | output | 1 | Data enable |
| pix_data | output | 24 | Pixel value, zero outside the window |
| pix_req | output | 1 | Stream pixel request strobe |

## Verification
Four small timings each run for two full frames, and every output is compared on every cycle against a counter model kept in the bench.

- The first timing uses the ramp source. Its enable window sits strictly inside both axes, which separates off-by-one window edges from correct ones and shows that the ramp restarts at the frame boundary.
- The second uses the constant source with a one-clock sync.
- The third uses the stream source with `src_sel` 00. The stream word changes every cycle, so a registered path shows up as a one-cycle lag.
- The fourth uses the stream source with `src_sel` 01. Its sync width is 0 and its vertical sync spans the whole frame. Its window covers every pixel, so the wrap cell itself is enabled.

Directed runs then cover reset overriding enable, a quiet hold, and a drop of enable in the middle of a frame followed by a restart.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_t;

    localparam logic [1:0] SRC_CONST = 2'b11;
    localparam logic [1:0] SRC_RAMP  = 2'b10;
endpackage

// File: rtl/vtg_axis_cnt.sv
// One timing axis: a wrapping counter plus its sync and window decodes.
module vtg_axis_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] sync_w,
    input  logic [CNT_W-1:0] win_min,
    input  logic [CNT_W-1:0] win_max,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             sync,
    output logic             in_win
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + ONE;
        end
    end

    always_comb begin
        last   = (cnt == total - ONE);
        sync   = (cnt < sync_w);
        in_win = (cnt >= win_min) && (cnt < win_max);
    end
endmodule

// File: rtl/vtg_pix_src.sv
// Pixel source selection and the per-frame ramp.
module vtg_pix_src
    import vtg_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             frame_wrap,
    input  logic             de,
    input  logic [1:0]       src_sel,
    input  logic [PIX_W-1:0] const_rgb,
    input  logic [PIX_W-1:0] strm_data,
    output logic [PIX_W-1:0] pix_data,
    output logic             pix_req
);
    localparam logic [PIX_W-1:0] ONE = PIX_W'(1);

    logic [PIX_W-1:0] ramp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp <= '0;
        end else if (clr || frame_wrap) begin
            ramp <= '0;
        end else if (de) begin
            ramp <= ramp + ONE;
        end
    end

    always_comb begin
        pix_data = '0;
        pix_req  = 1'b0;
        if (de) begin
            unique case (src_sel)
                SRC_CONST: pix_data = const_rgb;
                SRC_RAMP:  pix_data = ramp;
                default: begin
                    pix_data = strm_data;
                    pix_req  = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/pix_timing_gen.sv
module pix_timing_gen
    import vtg_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [1:0]       src_sel,
    input  logic [PIX_W-1:0] const_rgb,
    input  logic [PIX_W-1:0] strm_data,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] h_sync_w,
    input  logic [CNT_W-1:0] h_de_min,
    input  logic [CNT_W-1:0] h_de_max,
    input  logic [CNT_W-1:0] v_total,
    input  logic [CNT_W-1:0] v_sync_w,
    input  logic [CNT_W-1:0] v_de_min,
    input  logic [CNT_W-1:0] v_de_max,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [PIX_W-1:0] pix_data,
    output logic             pix_req
);
    gen_state_t state, state_nx;
    logic running;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic h_last, v_last, h_sync, v_sync, h_win, v_win;
    logic win_de;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD: if (run_en)  state_nx = ST_RUN;
            ST_RUN:  if (!run_en) state_nx = ST_HOLD;
        endcase
    end

    // Output decode per state
    always_comb begin
        running = 1'b0;
        hsync   = 1'b0;
        vsync   = 1'b0;
        win_de  = 1'b0;
        unique case (state)
            ST_HOLD: ;
            ST_RUN: begin
                running = 1'b1;
                hsync   = h_sync;
                vsync   = v_sync;
                win_de  = h_win && v_win;
            end
        endcase
    end

    assign de = win_de;

    vtg_axis_cnt #(.CNT_W(CNT_W)) u_h_axis (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(1'b1),
        .total(h_total), .sync_w(h_sync_w), .win_min(h_de_min), .win_max(h_de_max),
        .cnt(h_cnt), .last(h_last), .sync(h_sync), .in_win(h_win)
    );

    vtg_axis_cnt #(.CNT_W(CNT_W)) u_v_axis (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(h_last),
        .total(v_total), .sync_w(v_sync_w), .win_min(v_de_min), .win_max(v_de_max),
        .cnt(v_cnt), .last(v_last), .sync(v_sync), .in_win(v_win)
    );

    vtg_pix_src #(.PIX_W(PIX_W)) u_src (
        .clk(clk), .rst_n(rst_n), .clr(!running), .frame_wrap(h_last && v_last),
        .de(win_de), .src_sel(src_sel), .const_rgb(const_rgb), .strm_data(strm_data),
        .pix_data(pix_data), .pix_req(pix_req)
    );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int CNT_W = 16,
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic [CNT_W-1:0] h_cnt,
    input logic [CNT_W-1:0] v_cnt,
    input logic [CNT_W-1:0] h_total,
    input logic [1:0]       src_sel,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic             pix_req,
    input logic [PIX_W-1:0] pix_data
);
    p_quiet_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!hsync && !vsync && !de && !pix_req && pix_data == '0));

    p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && h_cnt != h_total - CNT_W'(1)) |=> (h_cnt == $past(h_cnt) + CNT_W'(1)));

    p_h_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && h_cnt == h_total - CNT_W'(1)) |=> (h_cnt == '0));

    p_v_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && h_cnt != h_total - CNT_W'(1)) |=> $stable(v_cnt));

    p_req_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> (de && !src_sel[1]));

    p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix_data == '0));
endmodule

bind pix_timing_gen vtg_checker #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_vtg_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_total(h_total), .src_sel(src_sel), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_req(pix_req), .pix_data(pix_data)
);

// File: tb/test_pix_timing_gen.sv
`timescale 1ns/1ps
module test_pix_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n, run_en;
    logic [1:0]  src_sel;
    logic [23:0] const_rgb, strm_data;
    logic [15:0] h_total, h_sync_w, h_de_min, h_de_max;
    logic [15:0] v_total, v_sync_w, v_de_min, v_de_max;
    logic        hsync, vsync, de, pix_req;
    logic [23:0] pix_data;

    always #2.5 clk = ~clk;

    pix_timing_gen i_pix_timing_gen (.*);

    // Per row: h_total, h_sync_w, h_de_min, h_de_max, v_total, v_sync_w, v_de_min, v_de_max
    localparam int NCFG = 4;
    localparam logic [15:0] CFG [NCFG][8] = '{
        '{16'd10, 16'd2, 16'd3, 16'd8,  16'd6, 16'd1, 16'd2, 16'd5},
        '{16'd8,  16'd1, 16'd2, 16'd7,  16'd5, 16'd2, 16'd2, 16'd4},
        '{16'd12, 16'd3, 16'd4, 16'd10, 16'd4, 16'd1, 16'd1, 16'd3},
        '{16'd7,  16'd0, 16'd0, 16'd7,  16'd3, 16'd3, 16'd0, 16'd3}
    };
    localparam logic [1:0] SRC [NCFG] = '{2'b10, 2'b11, 2'b00, 2'b01};

    int n_chk = 0, n_bad = 0;
    int eh, ev;
    logic [23:0] epat;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic apply_cfg(input int i);
        h_total = CFG[i][0]; h_sync_w = CFG[i][1]; h_de_min = CFG[i][2]; h_de_max = CFG[i][3];
        v_total = CFG[i][4]; v_sync_w = CFG[i][5]; v_de_min = CFG[i][6]; v_de_max = CFG[i][7];
        src_sel = SRC[i];
    endtask

    task automatic check_quiet(input string tag);
        chk(tag, {31'd0, hsync}, 32'd0);
        chk(tag, {31'd0, vsync}, 32'd0);
        chk(tag, {31'd0, de}, 32'd0);
        chk(tag, {31'd0, pix_req}, 32'd0);
        chk(tag, {8'd0, pix_data}, 32'd0);
    endtask

    // Raise run_en at a negedge; the next negedge is the first running cycle.
    task automatic start_run();
        @(negedge clk);
        run_en = 1'b1;
        eh = 0; ev = 0; epat = '0;
    endtask

    task automatic step_cmp(input int k);
        logic ehs, evs, ede, ereq;
        logic [23:0] edat;
        @(negedge clk);
        strm_data = {8'h5A, 16'(k * 37)};
        #0.5;
        ehs  = eh < int'(h_sync_w);
        evs  = ev < int'(v_sync_w);
        ede  = (eh >= int'(h_de_min)) && (eh < int'(h_de_max)) &&
               (ev >= int'(v_de_min)) && (ev < int'(v_de_max));
        ereq = ede && !src_sel[1];
        case (src_sel)
            2'b11:   edat = const_rgb;
            2'b10:   edat = epat;
            default: edat = strm_data;
        endcase
        if (!ede) edat = '0;
        chk("R2 hsync", {31'd0, hsync}, {31'd0, ehs});
        chk("R3 vsync", {31'd0, vsync}, {31'd0, evs});
        chk("R4 de", {31'd0, de}, {31'd0, ede});
        chk("R7 pix_req", {31'd0, pix_req}, {31'd0, ereq});
        if (!ede)                 chk("R8 blank data", {8'd0, pix_data}, {8'd0, edat});
        else if (src_sel == 2'b11) chk("R5 const data", {8'd0, pix_data}, {8'd0, edat});
        else if (src_sel == 2'b10) chk("R6 ramp data", {8'd0, pix_data}, {8'd0, edat});
        else                       chk("R7 stream data", {8'd0, pix_data}, {8'd0, edat});
        // advance the model
        if (eh == int'(h_total) - 1 && ev == int'(v_total) - 1) epat = '0;
        else if (ede) epat = epat + 24'd1;
        if (eh == int'(h_total) - 1) begin
            eh = 0;
            ev = (ev == int'(v_total) - 1) ? 0 : ev + 1;
        end else begin
            eh = eh + 1;
        end
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b1;
        const_rgb = 24'hC3A51E; strm_data = '0;
        apply_cfg(1);
        repeat (3) @(negedge clk);
        check_quiet("R1 reset overrides run_en");
        @(negedge clk);
        run_en = 1'b0; rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_quiet("R1 hold quiet");
        end

        // Table walk: two full frames per timing plus a few cycles
        for (int i = 0; i < NCFG; i++) begin
            @(negedge clk);
            run_en = 1'b0;
            apply_cfg(i);
            repeat (2) @(negedge clk);
            start_run();
            for (int k = 0; k < 2 * int'(h_total) * int'(v_total) + 3; k++) step_cmp(k);
        end

        // Mid-frame drop and restart (R1, R9)
        @(negedge clk);
        run_en = 1'b0;
        apply_cfg(0);
        repeat (2) @(negedge clk);
        start_run();
        for (int k = 0; k < 27; k++) step_cmp(k);
        run_en = 1'b0;
        @(negedge clk);
        #0.5;
        check_quiet("R1 quiet after drop");
        repeat (2) @(negedge clk);
        start_run();
        @(negedge clk);
        #0.5;
        chk("R9 restart hsync", {31'd0, hsync}, 32'd1);
        chk("R9 restart vsync", {31'd0, vsync}, 32'd1);
        eh = 1; ev = 0; epat = '0;
        for (int k = 0; k < 2 * 60 + 2; k++) step_cmp(k);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule